// File: doc/BRIEF.md
# Effective Address Sequencer

This block turns one memory operand specifier into an effective address and an operand value. A pulse on `start_i` hands it a mode code, a base register value, an index register value, a displacement or absolute field, and a two-bit scale code. The block then runs any memory reads the mode needs over a single-port read interface. That interface has a fixed latency of one cycle. At the end it raises `done_o` for one cycle, with the operand, the final address and, for the two self-updating modes, a new value for the base register.

Register and immediate operands need no reads. Most memory modes need one read. The memory-indirect mode needs two reads in a row: the word fetched from the base address becomes the address of the second read. While a request is in flight the block reports `busy_o` and ignores further start pulses. The register file, the ALU and the instruction decoder sit outside this block.

Top module: `opnd_addr_seq`

## Requirements
- R1: Mode code 2 (displacement) reads memory at field + base, and the operand is the word read there.
- R2: Mode code 3 (register indirect) reads at base. Mode code 4 (indexed) reads at base + index.
- R3: Mode code 5 (absolute) reads at the field value itself.
- R4: Mode code 9 (scaled) reads at field + base + (index × d), where d = 2^scale_i and scale_i values 0..3 give d = 1, 2, 4, 8.
- R5: Mode code 6 (memory indirect) performs exactly two reads. The first is at base. The second is at the word returned by the first. The operand is the second word, `ea_o` is the second address, and `done_o` rises in the fifth cycle after the start edge.
- R6: Mode code 7 (auto-increment) reads at base. Its writeback value is base + d.
- R7: Mode code 8 (auto-decrement) reads at base − d. Its writeback value is that same address.
- R8: Mode codes 0 (register) and 1 (immediate) issue no read. `done_o` rises in the first cycle after the start edge. The operand is the base value for code 0 and the field for code 1, and `ea_o` is zero.
- R9: Single-read modes raise `mem_re_o` for exactly one cycle, in the first cycle after the start edge. Read data is taken in the cycle after the read, and `done_o` is a one-cycle pulse in the third cycle after the start edge.
- R10: `wb_en_o` is high only in the `done_o` cycle and only for modes 7 and 8.
- R11: A start pulse that arrives while `busy_o` is high has no effect on the request in flight or on the reads issued.
- R12: After reset, `busy_o`, `done_o`, `mem_re_o` and `wb_en_o` are low.
- R13: Unused mode codes 10 to 15 behave as register mode (code 0).
- R14: All address arithmetic wraps modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted when not busy |
| mode_i | input | 4 | Addressing mode code |
| base_i | input | W | Base register value |
| index_i | input | W | Index register value |
| field_i | input | W | Displacement, absolute address or immediate |
| scale_i | input | 2 | Scale code, d = 2^scale_i |
| busy_o | output | 1 | Request in progress |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | W | Memory read address |
| mem_rdata_i | input | W | Read data, valid the cycle after the strobe |
| done_o | output | 1 | Operand valid pulse |
| operand_o | output | W | Fetched or direct operand |
| ea_o | output | W | Effective address of the final read |
| wb_en_o | output | 1 | Base-register writeback enable |
| wb_data_o | output | W | Base-register writeback value |

## Verification
The bench builds the block with W = 16. At that width, random sums of base, index, shifted index and field often pass 2^16. Auto-decrement from small bases then crosses below zero, so the wraparound of R14 is reached in normal traffic rather than only by hand-picked values. The bench memory returns a computed function of the address. Each memory-indirect case therefore sends its second read to an address unrelated to the first, which shows whether the returned word really steers the second read.

// File: rtl/eas_pkg.sv
package eas_pkg;

    typedef enum logic [3:0] {
        AM_REG    = 4'd0,
        AM_IMM    = 4'd1,
        AM_DISP   = 4'd2,
        AM_RIND   = 4'd3,
        AM_INDEX  = 4'd4,
        AM_ABS    = 4'd5,
        AM_MIND   = 4'd6,
        AM_AINC   = 4'd7,
        AM_ADEC   = 4'd8,
        AM_SCALED = 4'd9
    } amode_e;

    typedef struct packed {
        logic use_mem;
        logic two_reads;
        logic writes_base;
    } plan_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_RESP,
        ST_DONE
    } state_e;

    function automatic plan_t plan_for(input logic [3:0] m);
        plan_t p;
        p = '0;
        case (m)
            AM_DISP, AM_RIND, AM_INDEX, AM_ABS, AM_SCALED: p.use_mem = 1'b1;
            AM_MIND: begin
                p.use_mem   = 1'b1;
                p.two_reads = 1'b1;
            end
            AM_AINC, AM_ADEC: begin
                p.use_mem     = 1'b1;
                p.writes_base = 1'b1;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/eas_addr_calc.sv
module eas_addr_calc
    import eas_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   mode,
    input  logic [W-1:0] base,
    input  logic [W-1:0] index,
    input  logic [W-1:0] field,
    input  logic [1:0]   scale,
    output logic [W-1:0] ea,
    output logic [W-1:0] wb_val,
    output logic [W-1:0] direct_opnd,
    output plan_t        plan
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] step;
    logic [W-1:0] scaled_idx;

    always_comb begin
        step        = ONE << scale;
        scaled_idx  = index << scale;
        plan        = plan_for(mode);
        ea          = '0;
        wb_val      = '0;
        direct_opnd = base;
        case (mode)
            AM_IMM:    direct_opnd = field;
            AM_DISP:   ea = field + base;
            AM_RIND:   ea = base;
            AM_INDEX:  ea = base + index;
            AM_ABS:    ea = field;
            AM_MIND:   ea = base;
            AM_AINC: begin
                ea     = base;
                wb_val = base + step;
            end
            AM_ADEC: begin
                ea     = base - step;
                wb_val = base - step;
            end
            AM_SCALED: ea = field + base + scaled_idx;
            default:   direct_opnd = base;
        endcase
    end

endmodule

// File: rtl/eas_ctrl.sv
module eas_ctrl
    import eas_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  plan_t plan,
    output logic  accept,
    output logic  busy,
    output logic  issue,
    output logic  redirect,
    output logic  capture,
    output logic  done
);
    state_e state_q;
    logic   pend_q;

    assign accept   = start && (state_q == ST_IDLE);
    assign busy     = (state_q != ST_IDLE);
    assign issue    = (state_q == ST_REQ);
    assign redirect = (state_q == ST_RESP) && pend_q;
    assign capture  = (state_q == ST_RESP) && !pend_q;
    assign done     = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    pend_q  <= plan.two_reads;
                    state_q <= plan.use_mem ? ST_REQ : ST_DONE;
                end
                ST_REQ:  state_q <= ST_RESP;
                ST_RESP: begin
                    if (pend_q) begin
                        pend_q  <= 1'b0;
                        state_q <= ST_REQ;
                    end else begin
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/opnd_addr_seq.sv
module opnd_addr_seq
    import eas_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [3:0]   mode_i,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] index_i,
    input  logic [W-1:0] field_i,
    input  logic [1:0]   scale_i,
    output logic         busy_o,
    output logic         mem_re_o,
    output logic [W-1:0] mem_addr_o,
    input  logic [W-1:0] mem_rdata_i,
    output logic         done_o,
    output logic [W-1:0] operand_o,
    output logic [W-1:0] ea_o,
    output logic         wb_en_o,
    output logic [W-1:0] wb_data_o
);
    logic [W-1:0] calc_ea, calc_wb, calc_direct;
    plan_t        calc_plan;
    logic         accept, issue, redirect, capture, done;

    logic [W-1:0] addr_q, opnd_q, wb_q;
    logic         wben_q;

    eas_addr_calc #(.W(W)) u_calc (
        .mode        (mode_i),
        .base        (base_i),
        .index       (index_i),
        .field       (field_i),
        .scale       (scale_i),
        .ea          (calc_ea),
        .wb_val      (calc_wb),
        .direct_opnd (calc_direct),
        .plan        (calc_plan)
    );

    eas_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .plan     (calc_plan),
        .accept   (accept),
        .busy     (busy_o),
        .issue    (issue),
        .redirect (redirect),
        .capture  (capture),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            opnd_q <= '0;
            wb_q   <= '0;
            wben_q <= 1'b0;
        end else if (accept) begin
            addr_q <= calc_plan.use_mem ? calc_ea : '0;
            opnd_q <= calc_direct;
            wb_q   <= calc_wb;
            wben_q <= calc_plan.writes_base;
        end else if (redirect) begin
            addr_q <= mem_rdata_i;
        end else if (capture) begin
            opnd_q <= mem_rdata_i;
        end
    end

    assign mem_re_o   = issue;
    assign mem_addr_o = addr_q;
    assign done_o     = done;
    assign operand_o  = opnd_q;
    assign ea_o       = addr_q;
    assign wb_en_o    = done & wben_q;
    assign wb_data_o  = wb_q;

endmodule

// File: rtl/eas_chk.sv
module eas_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic [3:0]   mode_i,
    input logic         busy_o,
    input logic         mem_re_o,
    input logic         done_o,
    input logic         wb_en_o
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_read_in_flight_r9: assert property (@(posedge clk) disable iff (rst)
        mem_re_o |-> (busy_o && !done_o));

    p_direct_no_read_r8: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && (mode_i <= 4'd1)) |=> (done_o && !mem_re_o));

    p_mem_issue_r9: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && (mode_i >= 4'd2) && (mode_i <= 4'd9)) |=> mem_re_o);

    p_wb_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> done_o);

    p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    p_unused_direct_r13: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && (mode_i >= 4'd10)) |=> (done_o && !mem_re_o && !wb_en_o));
endmodule

bind opnd_addr_seq eas_chk #(.W(W)) u_chk (.*);

// File: tb/opnd_addr_seq_tb.sv
module opnd_addr_seq_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [3:0]   mode_i = '0;
    logic [W-1:0] base_i = '0, index_i = '0, field_i = '0;
    logic [1:0]   scale_i = '0;
    logic         busy_o, mem_re_o, done_o, wb_en_o;
    logic [W-1:0] mem_addr_o, operand_o, ea_o, wb_data_o;
    logic [W-1:0] mem_rdata_i = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rd_n   = 0;
    logic [W-1:0] rd_log [8];

    always #2.5 clk = ~clk;

    opnd_addr_seq #(.W(W)) u_dut (.*);

    function automatic logic [W-1:0] memf(input logic [W-1:0] a);
        return (a ^ W'(16'h5A3C)) + {a[W/2-1:0], a[W-1:W/2]} + W'(16'h0101);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_re_o) begin
            mem_rdata_i     <= memf(mem_addr_o);
            rd_log[rd_n % 8] <= mem_addr_o;
            rd_n            <= rd_n + 1;
        end
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired got=%0d exp<=100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0, 4'd1: return "R8";
            4'd2: return "R1";
            4'd3, 4'd4: return "R2";
            4'd5: return "R3";
            4'd6: return "R5";
            4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R4";
            default: return "R13";
        endcase
    endfunction

    // expected-value model written from the requirements
    task automatic run(input logic [3:0] m, input logic [W-1:0] b, input logic [W-1:0] x,
                       input logic [W-1:0] f, input logic [1:0] s, input bit intrude);
        logic [W-1:0] d, ea0, ea_exp, op_exp, wb_exp;
        int lat_exp, nrd_exp, lat, n0;
        bit wb_exp_en;
        string t;
        t = req_of(m);
        d = W'(1) << s;
        ea0 = '0; wb_exp = '0; wb_exp_en = 0; nrd_exp = 1; lat_exp = 3;
        case (m)
            4'd2: ea0 = f + b;
            4'd3: ea0 = b;
            4'd4: ea0 = b + x;
            4'd5: ea0 = f;
            4'd6: ea0 = b;
            4'd7: begin ea0 = b; wb_exp = b + d; wb_exp_en = 1; end
            4'd8: begin ea0 = b - d; wb_exp = b - d; wb_exp_en = 1; end
            4'd9: ea0 = f + b + (x << s);
            default: begin nrd_exp = 0; lat_exp = 1; end
        endcase
        if (nrd_exp == 0) begin
            ea_exp = '0;
            op_exp = (m == 4'd1) ? f : b;
        end else if (m == 4'd6) begin
            nrd_exp = 2; lat_exp = 5;
            ea_exp = memf(b);
            op_exp = memf(ea_exp);
        end else begin
            ea_exp = ea0;
            op_exp = memf(ea0);
        end
        @(negedge clk);
        n0 = rd_n;
        mode_i = m; base_i = b; index_i = x; field_i = f; scale_i = s;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 12) begin
            if (intrude && lat == 2) begin
                start_i = 1'b1; mode_i = 4'd5; field_i = ~f; base_i = ~b;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        if (intrude) t = {t, "/R11"};
        chk({t, " latency"}, W'(lat), W'(lat_exp));
        chk({t, " operand"}, operand_o, op_exp);
        chk({t, " ea"}, ea_o, ea_exp);
        chk({t, "/R10 wb_en"}, W'(wb_en_o), W'(wb_exp_en));
        if (wb_exp_en) chk({t, " wb_data"}, wb_data_o, wb_exp);
        chk({t, " read count"}, W'(rd_n - n0), W'(nrd_exp));
        if (nrd_exp >= 1) chk({t, " first read addr"}, rd_log[n0 % 8], ea0);
        if (nrd_exp == 2) chk({t, " second read addr"}, rd_log[(n0 + 1) % 8], memf(b));
        @(negedge clk);
        chk({t, "/R9 done one cycle"}, W'(done_o), W'(0));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 busy", W'(busy_o), '0);
        chk("R12 done", W'(done_o), '0);
        chk("R12 mem_re", W'(mem_re_o), '0);
        chk("R12 wb_en", W'(wb_en_o), '0);
        rst = 1'b0;
        // directed corners
        run(4'd0, 16'h1234, 16'h0, 16'hBEEF, 2'd0, 0);   // R8 register
        run(4'd1, 16'h1234, 16'h0, 16'hBEEF, 2'd0, 0);   // R8 immediate
        run(4'd2, 16'hFFF0, 16'h0, 16'h0020, 2'd0, 0);   // R1, R14 wrap
        run(4'd3, 16'h0400, 16'h0, 16'h0, 2'd0, 0);      // R2
        run(4'd4, 16'h8000, 16'h9000, 16'h0, 2'd0, 0);   // R2, R14 wrap
        run(4'd5, 16'h0, 16'h0, 16'h7777, 2'd0, 0);      // R3
        run(4'd6, 16'h0042, 16'h0, 16'h0, 2'd0, 0);      // R5
        run(4'd7, 16'hFFFC, 16'h0, 16'h0, 2'd3, 0);      // R6 wrap on writeback
        run(4'd8, 16'h0002, 16'h0, 16'h0, 2'd2, 0);      // R7 wrap below zero
        for (int s = 0; s < 4; s++)
            run(4'd9, 16'h0100, 16'h0003, 16'h0010, 2'(s), 0); // R4 each d
        run(4'd12, 16'hABCD, 16'h1, 16'h2, 2'd1, 0);     // R13
        run(4'd15, 16'h0F0F, 16'h1, 16'h2, 2'd1, 0);     // R13
        run(4'd6, 16'h1357, 16'h0, 16'h0, 2'd0, 1);      // R11 start while busy
        run(4'd2, 16'h2468, 16'h0, 16'h0004, 2'd0, 1);   // R11 single read
        // random traffic
        for (int i = 0; i < 300; i++)
            run(4'($urandom_range(0, 15)), W'($urandom), W'($urandom),
                W'($urandom), 2'($urandom_range(0, 3)), ($urandom_range(0, 9) == 0));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule